// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Controller

This block is a shared-memory controller for a small multicore system in which every core keeps at most one request in flight. Requests arrive over a valid/ready channel and are queued in arrival order in a single FIFO. They are then executed one at a time against an internal word array. Besides plain loads and stores, the controller runs test-and-set and fetch-and-increment/decrement itself. Each of these is a read, an optional one-cycle modify step and a write, and no other request can get between the read and the write. This gives software an atomic primitive without locking the interconnect.

Each operation type occupies the controller for a fixed number of cycles: load 5, store 4, test-and-set 9, fetch-and-add 10. A worst-case latency bound therefore follows directly from queue position and operation mix. Every request produces exactly one response on a second valid/ready channel, tagged with the requesting core's index. A load or atomic returns the value read. A store returns a zero-valued completion notice so that the core may issue its next request. When the response channel stalls, the finished response is held and the next queued request waits.

Top module: `atomic_mem_ctrl`

## Requirements
- R1: Requests are executed and answered strictly in the order they were accepted, whatever core issued them.
- R2: Service takes 5 cycles for a load, 4 for a store, 9 for test-and-set and 10 for fetch-and-add. With an idle controller and the response channel ready, rsp_valid goes high on the (service+1)-th rising edge after the edge that accepts the request.
- R3: Opcode 0 (load) returns the addressed word. Opcode 1 (store) writes req_wdata to the addressed word and answers with rsp_data equal to zero.
- R4: Opcode 2 (test-and-set) returns the old word and leaves the value 1 in memory.
- R5: Opcode 3 (fetch-and-add) returns the old word and writes back the old value plus one when req_wdata bit 0 is 0, or minus one when it is 1, wrapping modulo 2^DATA_W.
- R6: Every response carries, in rsp_core, the core index given with its request.
- R7: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_core and rsp_data stay unchanged and no queued request starts. The next queued request starts on the edge that accepts the held response.
- R8: req_ready is low exactly when the FIFO holds DEPTH requests that have not started.
- R9: After reset, rsp_valid is low, req_ready is high and every memory word reads as zero.
- R10: Between the read and the write of an atomic operation, the addressed word does not change.
- R11: No core has a second request accepted while its previous one is still unanswered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | FIFO can take a request |
| req_core | input | CID_W | Index of the requesting core |
| req_op | input | 2 | 0 load, 1 store, 2 test-and-set, 3 fetch-and-add |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data; bit 0 selects decrement for fetch-and-add |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Core takes the response |
| rsp_core | output | CID_W | Core the response belongs to |
| rsp_data | output | DATA_W | Value read, or zero for a store |

## Verification
The bench measures the response edge for each operation type on an idle controller. An off-by-one in the service counter, or a modify step that was skipped or doubled, shows up there as a response one edge early or late. Decrement from zero must wrap to all ones, and test-and-set on a value already set must still return that value. A wrong sign choice or a wrong stored constant is then caught by the next load. Under a stalled response channel the bench fills the FIFO and checks that req_ready drops. It then checks that the following store still needs its full latency after release: a design that started the queued request early would answer too soon or overwrite the held response. Long random runs over a handful of shared addresses confirm order and data against a bench model.

// File: rtl/atomic_mem_ctrl.sv
module atomic_mem_ctrl #(
  parameter int NCORES  = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 2,
  parameter int LD_CYC  = 5,
  parameter int ST_CYC  = 4,
  parameter int TAS_CYC = 9,
  parameter int FAA_CYC = 10,
  localparam int CID_W  = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CID_W-1:0]  req_core,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CID_W-1:0]  rsp_core,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int M1    = (LD_CYC > ST_CYC) ? LD_CYC : ST_CYC;
  localparam int M2    = (TAS_CYC > FAA_CYC) ? TAS_CYC : FAA_CYC;
  localparam int MAXL  = (M1 > M2) ? M1 : M2;
  localparam int CW    = $clog2(MAXL + 1);
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_TAS = 2'd2, OP_FAA = 2'd3;

  logic [DATA_W-1:0] mem [WORDS];

  logic [CID_W-1:0]  q_core [DEPTH];
  logic [1:0]        q_op   [DEPTH];
  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [DATA_W-1:0] q_wd   [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [PW:0]       q_cnt;

  logic              busy;
  logic [CW-1:0]     cnt, lat_cur;
  logic [CID_W-1:0]  cur_core;
  logic [1:0]        cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wd, rd_q, mod_q, wr_val;
  logic              push, start, last;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign req_ready = (q_cnt != (PW+1)'(DEPTH));
  assign push      = req_valid && req_ready;
  assign start     = !busy && (!rsp_valid || rsp_ready) && (q_cnt != '0);
  assign last      = busy && (cnt == lat_cur);

  always_comb begin
    case (cur_op)
      OP_LD:   lat_cur = CW'(LD_CYC);
      OP_ST:   lat_cur = CW'(ST_CYC);
      OP_TAS:  lat_cur = CW'(TAS_CYC);
      default: lat_cur = CW'(FAA_CYC);
    endcase
  end

  always_comb begin
    case (cur_op)
      OP_ST:   wr_val = cur_wd;
      OP_TAS:  wr_val = DATA_W'(1);
      default: wr_val = mod_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      q_cnt  <= '0;
    end else begin
      if (push) begin
        q_core[wr_ptr] <= req_core;
        q_op[wr_ptr]   <= req_op;
        q_addr[wr_ptr] <= req_addr;
        q_wd[wr_ptr]   <= req_wdata;
        wr_ptr         <= nxt(wr_ptr);
      end
      if (start) rd_ptr <= nxt(rd_ptr);
      q_cnt <= q_cnt + (PW+1)'(push) - (PW+1)'(start);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      cur_core  <= '0;
      cur_op    <= OP_LD;
      cur_addr  <= '0;
      cur_wd    <= '0;
      rd_q      <= '0;
      mod_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_core  <= '0;
      rsp_data  <= '0;
    end else begin
      if (start) begin
        busy     <= 1'b1;
        cnt      <= CW'(1);
        cur_core <= q_core[rd_ptr];
        cur_op   <= q_op[rd_ptr];
        cur_addr <= q_addr[rd_ptr];
        cur_wd   <= q_wd[rd_ptr];
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
      if (busy && cnt == CW'(1)) rd_q <= mem[cur_addr];
      if (busy && cur_op == OP_FAA && cnt == lat_cur - 1'b1)
        mod_q <= cur_wd[0] ? rd_q - 1'b1 : rd_q + 1'b1;
      if (last) begin
        rsp_valid <= 1'b1;
        rsp_core  <= cur_core;
        rsp_data  <= (cur_op == OP_ST) ? '0 : rd_q;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (last && cur_op != OP_LD) begin
      mem[cur_addr] <= wr_val;
    end
  end

  logic [NCORES-1:0] pend_q;
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else begin
      for (int c = 0; c < NCORES; c++) begin
        if (push && req_core == CID_W'(c)) pend_q[c] <= 1'b1;
        else if (rsp_valid && rsp_ready && rsp_core == CID_W'(c)) pend_q[c] <= 1'b0;
      end
    end
  end

  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !pend_q[req_core]);
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && !busy && $stable(rsp_core) && $stable(rsp_data)));
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt >= CW'(1) && cnt <= lat_cur));
  a_r2_rsp_ends_service: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(busy) && !busy);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= (PW+1)'(DEPTH));
  a_r10_atomic_window: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_op[1] && cnt >= CW'(2)) |-> (mem[cur_addr] == rd_q));
endmodule

// File: tb/atomic_mem_ctrl_tb_top.sv
module atomic_mem_ctrl_tb_top;
  localparam int NC = 4, AW = 6, DW = 32;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, TAS = 2'd2, FAA = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_ready, rsp_valid, rsp_ready = 1'b0;
  logic [1:0] req_core = '0, rsp_core;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, rsp_data;

  atomic_mem_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_core(rsp_core), .rsp_data(rsp_data));

  int checks = 0, fails = 0, cyc = 0, mode = 0;
  logic man_ready = 1'b1;
  logic [DW-1:0] mdl [64];
  logic [NC-1:0] pend = '0;
  logic [1:0]    e_core [$];
  logic [1:0]    e_op   [$];
  logic [DW-1:0] e_data [$];

  function automatic int lat_of(input logic [1:0] op);
    case (op) LD: return 5; ST: return 4; TAS: return 9; default: return 10; endcase
  endfunction

  function automatic logic [DW-1:0] new_val(input logic [1:0] op, input logic [DW-1:0] old, input logic [DW-1:0] wd);
    case (op)
      LD:      return old;
      ST:      return wd;
      TAS:     return 32'd1;
      default: return wd[0] ? old - 1 : old + 1;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] op);
    case (op) LD, ST: return "R3"; TAS: return "R4"; default: return "R5"; endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      rsp_ready = (mode == 1) ? (($urandom % 4) != 0) : man_ready;
      if (rsp_valid && rsp_ready) begin
        if (e_core.size() == 0) check(1'b0, "R1 unexpected response", DW'(rsp_core), '0);
        else begin
          logic [1:0] c, op;
          logic [DW-1:0] d;
          c = e_core.pop_front(); op = e_op.pop_front(); d = e_data.pop_front();
          check(rsp_core == c, "R1 R6 core", DW'(rsp_core), DW'(c));
          check(rsp_data == d, tag_of(op), rsp_data, d);
          pend[c] = 1'b0;
        end
      end
    end
  end

  task automatic send(input int c, input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    req_core = 2'(c); req_op = op; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    e_core.push_back(2'(c)); e_op.push_back(op);
    e_data.push_back(op == ST ? '0 : mdl[a]);
    mdl[a] = new_val(op, mdl[a], wd);
    pend[c] = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (e_core.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic measure(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    int n;
    send(0, op, a, wd);
    n = 0;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    check(n == lat_of(op) + 1, "R2 latency", DW'(n), DW'(lat_of(op) + 1));
    drain();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    repeat (5) @(negedge clk);
    check(rsp_valid == 1'b0, "R9 rsp_valid", DW'(rsp_valid), '0);
    check(req_ready == 1'b1, "R9 req_ready", DW'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    measure(LD, 6'd3, '0);                 // R9: zeroed memory
    measure(ST, 6'd3, 32'hA5);             // R3
    measure(TAS, 6'd3, '0);                // R4: returns A5
    measure(TAS, 6'd3, '0);                // R4: already set
    measure(FAA, 6'd3, 32'd0);             // R5: increment
    measure(FAA, 6'd4, 32'd1);             // R5: decrement wraps
    measure(LD, 6'd4, '0);
    measure(FAA, 6'd4, 32'd0);             // R5: wraps back to zero
    measure(LD, 6'd3, '0);

    man_ready = 1'b0;
    send(0, LD, 6'd3, '0);
    send(1, ST, 6'd6, 32'h1234);
    send(2, FAA, 6'd6, 32'd0);
    repeat (12) @(negedge clk);
    check(rsp_valid == 1'b1, "R7 held valid", DW'(rsp_valid), 32'd1);
    check(rsp_core == 2'd0, "R7 held core", DW'(rsp_core), '0);
    check(req_ready == 1'b0, "R8 full", DW'(req_ready), '0);
    held = rsp_data;
    repeat (5) @(negedge clk);
    check(rsp_data == held && rsp_valid, "R7 stable", rsp_data, held);
    man_ready = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!rsp_valid && n < 100);
    check(n == lat_of(ST) + 1, "R7 next starts at release", DW'(n), DW'(lat_of(ST) + 1));
    drain();

    mode = 1;
    for (int i = 0; i < 400; i++) begin
      int c;
      c = int'($urandom % NC);
      if (pend[c]) @(negedge clk);
      else send(c, 2'($urandom % 4), 6'($urandom % 8), $urandom);
    end
    drain();
    mode = 0;
    man_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(e_core.size() == 0, "R1 all answered", DW'(e_core.size()), '0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule